// File: doc/BRIEF.md
# Repeat-Prefixed String Operation Sequencer

This block carries out one string instruction element by element over a single synchronous memory read port. It handles three kinds of operation. A load copies a source element into the accumulator. A compare subtracts a destination element from a source element. A scan subtracts a destination element from the accumulator. Each runs at byte or word size. When a start strobe is accepted, the block latches the pointer registers, the count register, the accumulator, the segment values, the direction flag and the prefix code. It then issues reads, moves the pointers after each element and, under a repeat prefix, counts the count register down.

A repeat prefix keeps the sequence going until the count register reaches zero. For compare and scan, the sequence can also end early on the zero flag: one prefix code stops on equality and the other on inequality. The last element is followed by a one-cycle done pulse. The register and flag outputs then hold their final values until the next start.

Top module: `strseq_top`

## Requirements
- R1: With any prefix code other than 0xF2 or 0xF3, exactly one element is processed and the count output equals the count input, including when the count input is zero.
- R2: Under prefix 0xF2, elements repeat while the count is nonzero and the count drops by one per element. A compare or scan also stops after the first element whose result sets the zero flag.
- R3: Under prefix 0xF3, the same count rule applies. A compare or scan also stops after the first element whose result clears the zero flag.
- R4: A load (op code 0, and the spare code 3) never ends on the zero flag. Under either repeat prefix it runs until the count reaches zero, and it leaves the flags untouched.
- R5: If the count input is zero at start under 0xF2 or 0xF3, no read is issued and done is high in the cycle after the start edge. Pointers, count and flags are unchanged.
- R6: The source read address is (segment << 4) + SI truncated to 20 bits, using the override segment when seg_ovr_en_i is 1 and DS otherwise. The destination read address is (ES << 4) + DI. A compare (op 1) reads the source and then the destination; a scan (op 2) reads only the destination; a load reads only the source.
- R7: After each element, the pointers that were read move by 1 (byte, wide_i=0) or 2 (word, wide_i=1). They move up when df_i is 0 and down when it is 1, wrapping at 16 bits. SI moves for load and compare, DI moves for compare and scan.
- R8: A compare sets the flags from source minus destination, and a scan from accumulator minus destination, taken over the element width. The zero flag is set on a zero result, the carry flag on a borrow, the sign flag from the result's top bit, and the overflow flag on signed overflow.
- R9: A byte load replaces only acc bits 7:0 with mem_rdata_i bits 7:0 and keeps acc bits 15:8. A word load replaces all 16 bits.
- R10: mem_req_o is high for one cycle per read, and read data is taken from mem_rdata_i in the following cycle. No request is made while idle. done_o is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe, accepted while idle |
| op_i | input | 2 | 0 load, 1 compare, 2 scan, 3 treated as load |
| wide_i | input | 1 | 1 word elements, 0 byte elements |
| prefix_i | input | 8 | Repeat prefix code (0xF2, 0xF3, other = single) |
| seg_ovr_en_i | input | 1 | Use seg_ovr_i instead of DS for the source |
| seg_ovr_i | input | 16 | Override source segment |
| ds_i | input | 16 | Default source segment |
| es_i | input | 16 | Destination segment |
| si_i | input | 16 | Source pointer at start |
| di_i | input | 16 | Destination pointer at start |
| cx_i | input | 16 | Count at start |
| acc_i | input | 16 | Accumulator at start |
| df_i | input | 1 | Direction: 0 up, 1 down |
| mem_req_o | output | 1 | Read request |
| mem_addr_o | output | 20 | Read address |
| mem_wide_o | output | 1 | Read size, 1 word |
| mem_rdata_i | input | 16 | Read data, valid the cycle after the request |
| si_o | output | 16 | Current source pointer |
| di_o | output | 16 | Current destination pointer |
| cx_o | output | 16 | Current count |
| acc_o | output | 16 | Current accumulator |
| zf_o | output | 1 | Zero flag |
| cf_o | output | 1 | Carry (borrow) flag |
| sf_o | output | 1 | Sign flag |
| of_o | output | 1 | Overflow flag |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench places one mismatching byte in the middle of an otherwise equal compare region. A design with the two prefix polarities swapped stops after the first element instead of the fifth, or runs on to the end. A repeated load follows an operation that left the zero flag set; a design that lets the zero flag end loads stops after one element. Zero-count starts under both repeat prefixes expose a design that issues a read or reports done late, and a no-prefix run with a zero count exposes one that skips it. A word at offset 0xFFFE and a segment of 0xFFFF expose pointer wrap and 20-bit address truncation, and a signed-overflow byte compare exposes wrong carry, sign or overflow logic.

// File: rtl/strseq_pkg.sv
package strseq_pkg;

  localparam int unsigned WORD_W    = 16;
  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned SEG_SHIFT = 4;
  localparam int unsigned ADDR_W    = 20;

  localparam logic [7:0] PFX_NE = 8'hF2;
  localparam logic [7:0] PFX_EQ = 8'hF3;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [ADDR_W-1:0] addr_t;

  typedef enum logic [1:0] {
    OP_LOAD = 2'd0,
    OP_CMP  = 2'd1,
    OP_SCAN = 2'd2,
    OP_SPR  = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    RP_NONE = 2'd0,
    RP_NE   = 2'd1,
    RP_EQ   = 2'd2
  } rep_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SRC_REQ,
    ST_SRC_WAIT,
    ST_DST_REQ,
    ST_DST_WAIT
  } st_e;

  typedef struct packed {
    logic zf;
    logic cf;
    logic sf;
    logic of;
  } flags_t;

  function automatic rep_e decode_rep(logic [7:0] code);
    if (code == PFX_NE) return RP_NE;
    if (code == PFX_EQ) return RP_EQ;
    return RP_NONE;
  endfunction

  function automatic logic op_is_load(op_e op);
    return (op == OP_LOAD) || (op == OP_SPR);
  endfunction

  function automatic addr_t phys_addr(word_t seg, word_t ofs);
    addr_t base;
    addr_t off;
    base = addr_t'(seg) << SEG_SHIFT;
    off  = addr_t'(ofs);
    return base + off;
  endfunction

  function automatic word_t ptr_step(word_t p, logic wide, logic down);
    word_t amt;
    amt = wide ? word_t'(2) : word_t'(1);
    return down ? (p - amt) : (p + amt);
  endfunction

  function automatic flags_t sub_flags(word_t a, word_t b, logic wide);
    logic [WORD_W:0] dw;
    logic [BYTE_W:0] db;
    flags_t f;
    dw = {1'b0, a} - {1'b0, b};
    db = {1'b0, a[BYTE_W-1:0]} - {1'b0, b[BYTE_W-1:0]};
    if (wide) begin
      f.zf = (dw[WORD_W-1:0] == '0);
      f.cf = dw[WORD_W];
      f.sf = dw[WORD_W-1];
      f.of = (a[WORD_W-1] ^ b[WORD_W-1]) & (a[WORD_W-1] ^ dw[WORD_W-1]);
    end else begin
      f.zf = (db[BYTE_W-1:0] == '0);
      f.cf = db[BYTE_W];
      f.sf = db[BYTE_W-1];
      f.of = (a[BYTE_W-1] ^ b[BYTE_W-1]) & (a[BYTE_W-1] ^ db[BYTE_W-1]);
    end
    return f;
  endfunction

endpackage

// File: rtl/strseq_agen.sv
module strseq_agen
  import strseq_pkg::*;
(
  input  word_t src_seg,
  input  word_t dst_seg,
  input  word_t si,
  input  word_t di,
  input  logic  sel_dst,
  output addr_t addr
);

  addr_t src_addr;
  addr_t dst_addr;

  assign src_addr = phys_addr(src_seg, si);
  assign dst_addr = phys_addr(dst_seg, di);
  assign addr     = sel_dst ? dst_addr : src_addr;

endmodule

// File: rtl/strseq_cmp.sv
module strseq_cmp
  import strseq_pkg::*;
(
  input  word_t  lhs,
  input  word_t  rhs,
  input  logic   wide,
  output flags_t flags
);

  assign flags = sub_flags(lhs, rhs, wide);

endmodule

// File: rtl/strseq_fsm.sv
module strseq_fsm
  import strseq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  op_e  op_in,
  input  rep_e rep_in,
  input  logic cx_in_zero,
  input  op_e  op_q,
  input  rep_e rep_q,
  input  logic cx_last,
  input  logic zf_new,
  output logic accept_o,
  output logic busy_o,
  output logic req_o,
  output logic sel_dst_o,
  output logic cap_src_o,
  output logic cap_dst_o,
  output logic elem_end_o,
  output logic done_o
);

  st_e  st_q, st_d;
  logic done_d;
  logic skip_w;
  logic is_cmp_q;
  logic early_exit;
  logic stop_w;

  assign accept_o   = (st_q == ST_IDLE) && start_i;
  assign skip_w     = (rep_in != RP_NONE) && cx_in_zero;
  assign is_cmp_q   = !op_is_load(op_q);
  assign busy_o     = (st_q != ST_IDLE);
  assign req_o      = (st_q == ST_SRC_REQ) || (st_q == ST_DST_REQ);
  assign sel_dst_o  = (st_q == ST_DST_REQ);
  assign cap_src_o  = (st_q == ST_SRC_WAIT);
  assign cap_dst_o  = (st_q == ST_DST_WAIT);
  assign elem_end_o = ((st_q == ST_SRC_WAIT) && !is_cmp_q) || (st_q == ST_DST_WAIT);

  assign early_exit = is_cmp_q && ((rep_q == RP_NE) ? zf_new : !zf_new);
  assign stop_w     = (rep_q == RP_NONE) || cx_last || early_exit;

  always_comb begin
    st_d   = st_q;
    done_d = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (accept_o) begin
          if (skip_w)                st_d = ST_IDLE;
          else if (op_in == OP_SCAN) st_d = ST_DST_REQ;
          else                       st_d = ST_SRC_REQ;
          done_d = skip_w;
        end
      end
      ST_SRC_REQ: st_d = ST_SRC_WAIT;
      ST_SRC_WAIT: begin
        if (is_cmp_q) begin
          st_d = ST_DST_REQ;
        end else if (stop_w) begin
          st_d   = ST_IDLE;
          done_d = 1'b1;
        end else begin
          st_d = ST_SRC_REQ;
        end
      end
      ST_DST_REQ: st_d = ST_DST_WAIT;
      ST_DST_WAIT: begin
        if (stop_w) begin
          st_d   = ST_IDLE;
          done_d = 1'b1;
        end else if (op_q == OP_SCAN) begin
          st_d = ST_DST_REQ;
        end else begin
          st_d = ST_SRC_REQ;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      done_o <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_o <= done_d;
    end
  end

endmodule

// File: rtl/strseq_top.sv
module strseq_top
  import strseq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [1:0]        op_i,
  input  logic              wide_i,
  input  logic [7:0]        prefix_i,
  input  logic              seg_ovr_en_i,
  input  logic [WORD_W-1:0] seg_ovr_i,
  input  logic [WORD_W-1:0] ds_i,
  input  logic [WORD_W-1:0] es_i,
  input  logic [WORD_W-1:0] si_i,
  input  logic [WORD_W-1:0] di_i,
  input  logic [WORD_W-1:0] cx_i,
  input  logic [WORD_W-1:0] acc_i,
  input  logic              df_i,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_wide_o,
  input  logic [WORD_W-1:0] mem_rdata_i,
  output logic [WORD_W-1:0] si_o,
  output logic [WORD_W-1:0] di_o,
  output logic [WORD_W-1:0] cx_o,
  output logic [WORD_W-1:0] acc_o,
  output logic              zf_o,
  output logic              cf_o,
  output logic              sf_o,
  output logic              of_o,
  output logic              done_o
);

  word_t  si_q, di_q, cx_q, acc_q, src_tmp_q;
  word_t  src_seg_q, dst_seg_q;
  op_e    op_q;
  rep_e   rep_q;
  logic   wide_q, df_q;
  flags_t flags_q;

  op_e    op_in_w;
  rep_e   rep_in_w;
  word_t  cx_dec_w;
  word_t  cmp_lhs_w;
  flags_t cmp_flags_w;
  logic   load_q_w;

  logic   accept_w, busy_w, req_w, sel_dst_w;
  logic   cap_src_w, cap_dst_w, elem_end_w;

  assign op_in_w   = op_e'(op_i);
  assign rep_in_w  = decode_rep(prefix_i);
  assign cx_dec_w  = cx_q - word_t'(1);
  assign load_q_w  = op_is_load(op_q);
  assign cmp_lhs_w = (op_q == OP_SCAN) ? acc_q : src_tmp_q;

  strseq_fsm fsm_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .op_in      (op_in_w),
    .rep_in     (rep_in_w),
    .cx_in_zero (cx_i == '0),
    .op_q       (op_q),
    .rep_q      (rep_q),
    .cx_last    (cx_dec_w == '0),
    .zf_new     (cmp_flags_w.zf),
    .accept_o   (accept_w),
    .busy_o     (busy_w),
    .req_o      (req_w),
    .sel_dst_o  (sel_dst_w),
    .cap_src_o  (cap_src_w),
    .cap_dst_o  (cap_dst_w),
    .elem_end_o (elem_end_w),
    .done_o     (done_o)
  );

  strseq_agen agen_i (
    .src_seg (src_seg_q),
    .dst_seg (dst_seg_q),
    .si      (si_q),
    .di      (di_q),
    .sel_dst (sel_dst_w),
    .addr    (mem_addr_o)
  );

  strseq_cmp cmp_i (
    .lhs   (cmp_lhs_w),
    .rhs   (mem_rdata_i),
    .wide  (wide_q),
    .flags (cmp_flags_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      si_q      <= '0;
      di_q      <= '0;
      cx_q      <= '0;
      acc_q     <= '0;
      src_tmp_q <= '0;
      src_seg_q <= '0;
      dst_seg_q <= '0;
      op_q      <= OP_LOAD;
      rep_q     <= RP_NONE;
      wide_q    <= 1'b0;
      df_q      <= 1'b0;
      flags_q   <= '0;
    end else begin
      if (accept_w) begin
        si_q      <= si_i;
        di_q      <= di_i;
        cx_q      <= cx_i;
        acc_q     <= acc_i;
        src_seg_q <= seg_ovr_en_i ? seg_ovr_i : ds_i;
        dst_seg_q <= es_i;
        op_q      <= op_in_w;
        rep_q     <= rep_in_w;
        wide_q    <= wide_i;
        df_q      <= df_i;
      end
      if (cap_src_w) begin
        si_q <= ptr_step(si_q, wide_q, df_q);
        if (load_q_w) begin
          if (wide_q) acc_q <= mem_rdata_i;
          else        acc_q <= {acc_q[WORD_W-1:BYTE_W], mem_rdata_i[BYTE_W-1:0]};
        end else begin
          src_tmp_q <= mem_rdata_i;
        end
      end
      if (cap_dst_w) begin
        di_q    <= ptr_step(di_q, wide_q, df_q);
        flags_q <= cmp_flags_w;
      end
      if (elem_end_w && (rep_q != RP_NONE)) begin
        cx_q <= cx_dec_w;
      end
    end
  end

  assign mem_req_o  = req_w;
  assign mem_wide_o = wide_q;
  assign si_o       = si_q;
  assign di_o       = di_q;
  assign cx_o       = cx_q;
  assign acc_o      = acc_q;
  assign zf_o       = flags_q.zf;
  assign cf_o       = flags_q.cf;
  assign sf_o       = flags_q.sf;
  assign of_o       = flags_q.of;

endmodule

// File: rtl/strseq_chk.sv
module strseq_chk
  import strseq_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        accept,
  input logic        busy,
  input logic        done,
  input logic        mem_req,
  input logic [7:0]  prefix,
  input logic [15:0] cx_in,
  input logic [1:0]  rep_q,
  input logic        is_load,
  input logic [15:0] cx,
  input logic        zf,
  input logic [15:0] si,
  input logic        wide_q,
  input logic        df_q
);

  logic [15:0] amt;
  assign amt = wide_q ? 16'd2 : 16'd1;

  // R5
  skip_no_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept && ((prefix == PFX_NE) || (prefix == PFX_EQ)) && (cx_in == 16'd0)
      |=> done && !mem_req);

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10
  idle_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req);

  // R4
  load_runs_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && is_load && (rep_q != 2'd0) |-> (cx == 16'd0));

  // R2
  ne_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && (rep_q == 2'd1) && (cx != 16'd0) |-> zf);

  // R3
  eq_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && (rep_q == 2'd2) && (cx != 16'd0) |-> !zf);

  // R7
  si_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) && (si != $past(si))
      |-> (df_q ? (($past(si) - si) == amt) : ((si - $past(si)) == amt)));

endmodule

bind strseq_top strseq_chk chk_i (
  .clk     (clk),
  .rst_n   (rst_n),
  .accept  (accept_w),
  .busy    (busy_w),
  .done    (done_o),
  .mem_req (mem_req_o),
  .prefix  (prefix_i),
  .cx_in   (cx_i),
  .rep_q   (rep_q),
  .is_load (load_q_w),
  .cx      (cx_o),
  .zf      (zf_o),
  .si      (si_o),
  .wide_q  (wide_q),
  .df_q    (df_q)
);

// File: tb/strseq_top_tb_top.sv
`timescale 1ns/1ps
module strseq_top_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [1:0]  op_i = '0;
  logic        wide_i = 1'b0;
  logic [7:0]  prefix_i = '0;
  logic        seg_ovr_en_i = 1'b0;
  logic [15:0] seg_ovr_i = '0;
  logic [15:0] ds_i = 16'h0010;
  logic [15:0] es_i = 16'h0020;
  logic [15:0] si_i = '0, di_i = '0, cx_i = '0, acc_i = '0;
  logic        df_i = 1'b0;
  logic        mem_req_o, mem_wide_o;
  logic [19:0] mem_addr_o;
  logic [15:0] mem_rdata_i = '0;
  logic [15:0] si_o, di_o, cx_o, acc_o;
  logic        zf_o, cf_o, sf_o, of_o, done_o;

  always #2 clk = ~clk;

  strseq_top dut_i (.*);

  logic [7:0]  mem [0:4095];
  int          total_reads = 0;
  logic [19:0] addr_log [0:255];
  int          n_checks = 0;
  int          n_errors = 0;
  int          cycles = 0;
  int          got_reads, got_cycles;
  logic [19:0] got_addr;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (mem_req_o) begin
      addr_log[total_reads[7:0]] <= mem_addr_o;
      total_reads <= total_reads + 1;
      if (mem_wide_o)
        mem_rdata_i <= {mem[mem_addr_o[11:0] + 12'd1], mem[mem_addr_o[11:0]]};
      else
        mem_rdata_i <= {8'hEE, mem[mem_addr_o[11:0]]};
    end
  end

  initial begin
    wait (cycles > 100000);
    n_errors++;
    $display("FAIL watchdog: run did not finish act=%0d exp<=%0d", cycles, 100000);
    $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  task automatic run_op(input logic [1:0] op, input logic w, input logic [7:0] pfx,
                        input logic ovr, input logic [15:0] ovseg, input logic df,
                        input logic [15:0] si, input logic [15:0] di,
                        input logic [15:0] cx, input logic [15:0] acc);
    int base;
    int cyc;
    @(negedge clk);
    op_i = op; wide_i = w; prefix_i = pfx; seg_ovr_en_i = ovr; seg_ovr_i = ovseg;
    df_i = df; si_i = si; di_i = di; cx_i = cx; acc_i = acc; start_i = 1'b1;
    base = total_reads;
    @(negedge clk);
    start_i = 1'b0;
    cyc = 1;
    while (!done_o && cyc < 5000) begin
      @(negedge clk);
      cyc++;
    end
    got_cycles = cyc;
    got_reads  = total_reads - base;
    got_addr   = addr_log[base[7:0]];
    chk("R10", "done seen", {31'd0, done_o}, 32'd1);
  endtask

  task automatic chk_pulse_end();
    @(negedge clk);
    chk("R10", "done low after pulse", {31'd0, done_o}, 32'd0);
    chk("R10", "no request after done", {31'd0, mem_req_o}, 32'd0);
  endtask

  typedef struct packed {
    logic [1:0]  op;
    logic        w;
    logic [7:0]  pfx;
    logic        ovr;
    logic [15:0] ovseg;
    logic        df;
    logic [15:0] si, di, cx, acc;
    logic [15:0] e_si, e_di, e_cx, e_acc;
    logic [3:0]  e_flg;
    logic [7:0]  e_reads;
    logic [19:0] e_addr;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VEC [0:NV-1] = '{
    '{2'd0,1'b0,8'h00,1'b0,16'h0000,1'b0,16'h0040,16'h0000,16'd5,16'h1234,16'h0041,16'h0000,16'd5,16'h1240,4'b0000,8'd1,20'h00140},
    '{2'd0,1'b1,8'h00,1'b1,16'h0030,1'b0,16'h0050,16'h0000,16'd0,16'h0000,16'h0052,16'h0000,16'd0,16'h5150,4'b0000,8'd1,20'h00350},
    '{2'd0,1'b0,8'hF3,1'b0,16'h0000,1'b1,16'h0060,16'h0000,16'd3,16'hFF00,16'h005D,16'h0000,16'd0,16'hFF5E,4'b0000,8'd3,20'h00160},
    '{2'd1,1'b0,8'hF3,1'b0,16'h0000,1'b0,16'h0044,16'h0044,16'd8,16'h0000,16'h0049,16'h0049,16'd3,16'h0000,4'b0000,8'd10,20'h00144},
    '{2'd1,1'b0,8'hF2,1'b0,16'h0000,1'b0,16'h0044,16'h0044,16'd8,16'h0000,16'h0045,16'h0045,16'd7,16'h0000,4'b1000,8'd2,20'h00144},
    '{2'd2,1'b0,8'hF2,1'b0,16'h0000,1'b0,16'h0000,16'h0044,16'd10,16'h004B,16'h0000,16'h004C,16'd2,16'h004B,4'b1000,8'd8,20'h00244},
    '{2'd2,1'b1,8'hF3,1'b0,16'h0000,1'b0,16'h0000,16'h0080,16'd4,16'h8180,16'h0000,16'h0084,16'd2,16'h8180,4'b0110,8'd2,20'h00280},
    '{2'd1,1'b1,8'h00,1'b0,16'h0000,1'b1,16'h0090,16'h0090,16'd9,16'h0000,16'h008E,16'h008E,16'd9,16'h0000,4'b1000,8'd2,20'h00190},
    '{2'd0,1'b0,8'hF2,1'b0,16'h0000,1'b0,16'h0070,16'h0000,16'd4,16'h0000,16'h0074,16'h0000,16'd0,16'h0073,4'b1000,8'd4,20'h00170},
    '{2'd1,1'b0,8'h00,1'b1,16'h0030,1'b0,16'h00A0,16'h00A0,16'd1,16'h0000,16'h00A1,16'h00A1,16'd1,16'h0000,4'b0111,8'd2,20'h003A0},
    '{2'd0,1'b1,8'h00,1'b0,16'h0000,1'b0,16'hFFFE,16'h0000,16'd0,16'h0000,16'h0000,16'h0000,16'd0,16'hFFFE,4'b0111,8'd1,20'h100FE}
  };

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = i[7:0];
    mem[12'h248] = 8'h00;
    mem[12'h3A0] = 8'h7F;
    mem[12'h2A0] = 8'h80;

    repeat (3) @(negedge clk);
    // reset state
    chk("R10", "reset done", {31'd0, done_o}, 32'd0);
    chk("R10", "reset req", {31'd0, mem_req_o}, 32'd0);
    chk("R8", "reset flags", {28'd0, zf_o, cf_o, sf_o, of_o}, 32'd0);
    chk("R7", "reset si", {16'd0, si_o}, 32'd0);
    rst_n = 1'b1;

    for (int v = 0; v < NV; v++) begin
      string ctag;
      vec_t t;
      t = VEC[v];
      if (t.pfx == 8'hF2)      ctag = ((t.op == 2'd0) ? "R4" : "R2");
      else if (t.pfx == 8'hF3) ctag = ((t.op == 2'd0) ? "R4" : "R3");
      else                     ctag = "R1";
      run_op(t.op, t.w, t.pfx, t.ovr, t.ovseg, t.df, t.si, t.di, t.cx, t.acc);
      chk(ctag,  $sformatf("vec %0d cx", v),    {16'd0, cx_o},  {16'd0, t.e_cx});
      chk("R7",  $sformatf("vec %0d si", v),    {16'd0, si_o},  {16'd0, t.e_si});
      chk("R7",  $sformatf("vec %0d di", v),    {16'd0, di_o},  {16'd0, t.e_di});
      chk("R9",  $sformatf("vec %0d acc", v),   {16'd0, acc_o}, {16'd0, t.e_acc});
      chk("R8",  $sformatf("vec %0d flags", v), {28'd0, zf_o, cf_o, sf_o, of_o}, {28'd0, t.e_flg});
      chk("R6",  $sformatf("vec %0d reads", v), got_reads, {24'd0, t.e_reads});
      chk("R6",  $sformatf("vec %0d first addr", v), {12'd0, got_addr}, {12'd0, t.e_addr});
      chk_pulse_end();
    end

    // R5: zero count under 0xF2, compare
    run_op(2'd1, 1'b0, 8'hF2, 1'b0, 16'h0000, 1'b0, 16'h0033, 16'h0044, 16'd0, 16'h0000);
    chk("R5", "F2 zero count latency", got_cycles, 32'd1);
    chk("R5", "F2 zero count reads", got_reads, 32'd0);
    chk("R5", "F2 zero count si", {16'd0, si_o}, 32'h0033);
    chk("R5", "F2 zero count di", {16'd0, di_o}, 32'h0044);
    chk("R5", "F2 zero count flags", {28'd0, zf_o, cf_o, sf_o, of_o}, 32'b0111);
    chk_pulse_end();

    // R5: zero count under 0xF3, scan
    run_op(2'd2, 1'b1, 8'hF3, 1'b0, 16'h0000, 1'b1, 16'h0011, 16'h0022, 16'd0, 16'h0000);
    chk("R5", "F3 zero count latency", got_cycles, 32'd1);
    chk("R5", "F3 zero count reads", got_reads, 32'd0);
    chk("R5", "F3 zero count di", {16'd0, di_o}, 32'h0022);
    chk("R5", "F3 zero count cx", {16'd0, cx_o}, 32'd0);
    chk_pulse_end();

    // R6: 20-bit truncation with override segment
    run_op(2'd0, 1'b0, 8'h00, 1'b1, 16'hFFFF, 1'b0, 16'h0020, 16'h0000, 16'd2, 16'hAA00);
    chk("R6", "truncated address", {12'd0, got_addr}, 32'h00010);
    chk("R9", "byte load keeps high", {16'd0, acc_o}, 32'hAA10);
    chk("R7", "si after trunc load", {16'd0, si_o}, 32'h0021);
    chk_pulse_end();

    // R1: unrelated prefix code runs once
    run_op(2'd3, 1'b0, 8'h66, 1'b0, 16'h0000, 1'b0, 16'h0075, 16'h0000, 16'd3, 16'h0000);
    chk("R1", "other prefix reads", got_reads, 32'd1);
    chk("R1", "other prefix cx", {16'd0, cx_o}, 32'd3);
    chk("R9", "spare code loads", {16'd0, acc_o}, 32'h0075);
    chk_pulse_end();

    $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end

endmodule